// File: doc/BRIEF.md
# Processor exception entry controller

This block decides, once per cycle, whether the core enters a handler, and if it does it produces every state change that entry needs. Five event sources compete: an MMU fault, a hardware exception, a hardware break, a software break and a pending interrupt line. The block takes the current PC, the current status word, the branch target and the per-instruction flags (delay slot, immediate prefix, prefixed branch). It grants at most one event, writes the return address to the proper link register, saves and clears the mode bits of the status word, and redirects the PC.

The block owns the exception syndrome, saved branch target and fault address registers. The status word belongs to the core: the block reads it on `msr_i` and hands back the updated value on `msr_o`, which is valid whenever `entry_taken_o` is high. All results are registered and appear one clock after the request cycle. Vector addresses are fixed offsets from the `VEC_BASE` parameter.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several requests are present in one cycle, exactly one is granted in the order MMU fault, hardware exception, hardware break, software break, interrupt. `entry_taken_o` is high for one cycle per grant, one cycle after the request, and it stays low in a cycle after a cycle with no grant.
- R2: The new PC is `VEC_BASE`+0x10 for an interrupt, `VEC_BASE`+0x18 for a hardware break, and `VEC_BASE`+0x20 for a hardware exception or an MMU fault. A software break goes to `btarget_i`.
- R3: An interrupt is granted only if status bit 1 (interrupt enable) is 1, status bit 9 (exception in progress) is 0, status bit 3 (break in progress) is 0, `in_dslot_i` is 0 and `has_imm_i` is 0. Otherwise it has no effect on any output.
- R4: On every entry, `msr_o` has bit 12 equal to the old bit 11 (user mode) and bit 14 equal to the old bit 13 (virtual mode), with bits 11 and 13 cleared. Other bits pass through unless a later requirement changes them.
- R5: Interrupt entry clears status bit 1 and writes the PC to link register 14.
- R6: Hardware exception entry writes PC+4 to link register 17 and sets status bit 9. While `cfg_exc_en_i` is 0, a hardware exception request has no effect, and a lower-priority request may be granted instead.
- R7: MMU fault entry writes to link register 17 the PC minus 8 when `in_dslot_i` and `branch_imm_i` are both set, minus 4 when only `in_dslot_i` is set, minus 4 when only `has_imm_i` is set, and the PC itself otherwise. It sets status bit 9.
- R8: On hardware exception and MMU fault entry, syndrome bit 12 becomes `in_dslot_i`. `btr_o` takes `btarget_i` only when `in_dslot_i` is set and otherwise holds its value. A hardware exception leaves the other syndrome bits unchanged.
- R9: On an MMU fault, the syndrome becomes code[4:0] = 16 + 2*kind + fetch, where `mmu_kind_i` is 0 for a protection fault and 1 for a miss, and fetch means `mmu_acc_i`=0 (1 is load, 2 is store). Bit 10 is 1 for a store, bit 12 follows R8, and all other bits are 0. `ear_o` takes `fault_addr_i`, and `ear_o` changes on no other entry.
- R10: Break entry sets status bit 3. A hardware break writes the PC to link register 16. A software break writes no link register.
- R11: `clr_flags_o` pulses together with the entry of a hardware exception or an MMU fault and is low on every other entry and cycle.
- R12: After reset, `entry_taken_o`, `link_we_o` and `clr_flags_o` are 0, and `esr_o`, `btr_o` and `ear_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | PC of the current instruction |
| msr_i | input | 32 | Current status word |
| btarget_i | input | 32 | Branch target of the current branch |
| fault_addr_i | input | 32 | Faulting virtual address |
| in_dslot_i | input | 1 | Instruction is in a delay slot |
| has_imm_i | input | 1 | Instruction carries an immediate prefix |
| branch_imm_i | input | 1 | The owning branch had an immediate prefix |
| cfg_exc_en_i | input | 1 | Hardware exceptions are enabled |
| irq_i | input | 1 | Pending interrupt |
| hw_exc_req_i | input | 1 | Hardware exception request |
| mmu_fault_req_i | input | 1 | MMU fault request |
| mmu_kind_i | input | 1 | 0 protection, 1 miss |
| mmu_acc_i | input | 2 | 0 fetch, 1 load, 2 store |
| sw_break_req_i | input | 1 | Software break request |
| hw_break_req_i | input | 1 | Hardware break request |
| entry_taken_o | output | 1 | One-cycle entry strobe |
| new_pc_o | output | 32 | Handler PC, valid with the strobe |
| msr_o | output | 32 | Updated status word, valid with the strobe |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register number |
| link_data_o | output | 32 | Return address |
| clr_flags_o | output | 1 | Clear delay-slot and prefix flags |
| esr_o | output | 32 | Exception syndrome register |
| btr_o | output | 32 | Saved branch target register |
| ear_o | output | 32 | Fault address register |

## Verification
Every result has exactly one register stage: the strobe, PC, status word, link write, flag clear and the syndrome, branch target and fault address registers all appear on the clock edge that samples the request. The bench drives each request half a cycle before that edge and compares all outputs half a cycle after it. It then holds the inputs idle for one more cycle and checks that the strobe and the link write have dropped and that the owned registers still hold their values. Requests that must not be granted are checked in the same cycle slot, by confirming that no output moved.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;
  localparam int XLEN = 32;

  // status word bit positions; saved copies sit one place left of live bits
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;

  localparam int ESR_DS    = 12;
  localparam int ESR_STORE = 10;

  localparam logic [4:0] LINK_IRQ = 5'd14;
  localparam logic [4:0] LINK_BRK = 5'd16;
  localparam logic [4:0] LINK_EXC = 5'd17;

  localparam logic [XLEN-1:0] OFS_IRQ = 32'h10;
  localparam logic [XLEN-1:0] OFS_BRK = 32'h18;
  localparam logic [XLEN-1:0] OFS_EXC = 32'h20;

  typedef enum logic [2:0] {
    EV_NONE, EV_MMU, EV_HWEXC, EV_HWBRK, EV_SWBRK, EV_IRQ
  } ev_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2
  } acc_e;
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         mmu_i,
  input  logic         hwexc_i,
  input  logic         hwbrk_i,
  input  logic         swbrk_i,
  input  logic         irq_i,
  input  logic         exc_en_i,
  input  logic [W-1:0] msr_i,
  input  logic         in_dslot_i,
  input  logic         has_imm_i,
  output ev_e          ev_o
);
  logic irq_ok;

  always_comb begin
    irq_ok = irq_i & msr_i[MSR_IE] & ~msr_i[MSR_EIP] & ~msr_i[MSR_BIP]
           & ~in_dslot_i & ~has_imm_i;
    if (mmu_i)                    ev_o = EV_MMU;
    else if (hwexc_i && exc_en_i) ev_o = EV_HWEXC;
    else if (hwbrk_i)             ev_o = EV_HWBRK;
    else if (swbrk_i)             ev_o = EV_SWBRK;
    else if (irq_ok)              ev_o = EV_IRQ;
    else                          ev_o = EV_NONE;
  end
endmodule

// File: rtl/exc_msr_update.sv
`timescale 1ns/1ps
module exc_msr_update
  import exc_entry_pkg::*;
#(
  parameter int W = XLEN
) (
  input  ev_e          ev_i,
  input  logic [W-1:0] msr_i,
  output logic [W-1:0] msr_o
);
  always_comb begin
    msr_o          = msr_i;
    msr_o[MSR_UMS] = msr_i[MSR_UM];
    msr_o[MSR_VMS] = msr_i[MSR_VM];
    msr_o[MSR_UM]  = 1'b0;
    msr_o[MSR_VM]  = 1'b0;
    unique case (ev_i)
      EV_IRQ:            msr_o[MSR_IE]  = 1'b0;
      EV_MMU, EV_HWEXC:  msr_o[MSR_EIP] = 1'b1;
      EV_HWBRK, EV_SWBRK: msr_o[MSR_BIP] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_link_calc.sv
`timescale 1ns/1ps
module exc_link_calc
  import exc_entry_pkg::*;
#(
  parameter int W = XLEN
) (
  input  ev_e          ev_i,
  input  logic [W-1:0] pc_i,
  input  logic         in_dslot_i,
  input  logic         has_imm_i,
  input  logic         branch_imm_i,
  output logic         we_o,
  output logic [4:0]   idx_o,
  output logic [W-1:0] data_o
);
  localparam logic [W-1:0] WORD = W'(4);

  logic [W-1:0] rewind;

  always_comb begin
    // delay slot re-runs the branch, and its prefix too if it had one
    if (in_dslot_i)     rewind = branch_imm_i ? (WORD << 1) : WORD;
    else if (has_imm_i) rewind = WORD;
    else                rewind = '0;

    we_o   = 1'b1;
    idx_o  = LINK_EXC;
    data_o = pc_i;
    unique case (ev_i)
      EV_MMU:   data_o = pc_i - rewind;
      EV_HWEXC: data_o = pc_i + WORD;
      EV_HWBRK: idx_o  = LINK_BRK;
      EV_IRQ:   idx_o  = LINK_IRQ;
      default:  we_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_syndrome.sv
`timescale 1ns/1ps
module exc_syndrome
  import exc_entry_pkg::*;
#(
  parameter int W = XLEN
) (
  input  ev_e          ev_i,
  input  logic         in_dslot_i,
  input  logic         kind_i,
  input  logic [1:0]   acc_i,
  input  logic [W-1:0] btarget_i,
  input  logic [W-1:0] fault_addr_i,
  input  logic [W-1:0] esr_q_i,
  input  logic [W-1:0] btr_q_i,
  input  logic [W-1:0] ear_q_i,
  output logic [W-1:0] esr_d_o,
  output logic [W-1:0] btr_d_o,
  output logic [W-1:0] ear_d_o
);
  logic [4:0] code;
  logic       is_exc;

  always_comb begin
    code   = {3'b100, kind_i, acc_i == ACC_FETCH};
    is_exc = (ev_i == EV_MMU) || (ev_i == EV_HWEXC);

    esr_d_o = esr_q_i;
    ear_d_o = ear_q_i;
    if (ev_i == EV_MMU) begin
      esr_d_o            = '0;
      esr_d_o[4:0]       = code;
      esr_d_o[ESR_STORE] = (acc_i == ACC_STORE);
      ear_d_o            = fault_addr_i;
    end
    if (is_exc) esr_d_o[ESR_DS] = in_dslot_i;

    btr_d_o = (is_exc && in_dslot_i) ? btarget_i : btr_q_i;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              W        = XLEN,
  parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_1000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] msr_i,
  input  logic [W-1:0] btarget_i,
  input  logic [W-1:0] fault_addr_i,
  input  logic         in_dslot_i,
  input  logic         has_imm_i,
  input  logic         branch_imm_i,
  input  logic         cfg_exc_en_i,
  input  logic         irq_i,
  input  logic         hw_exc_req_i,
  input  logic         mmu_fault_req_i,
  input  logic         mmu_kind_i,
  input  logic [1:0]   mmu_acc_i,
  input  logic         sw_break_req_i,
  input  logic         hw_break_req_i,
  output logic         entry_taken_o,
  output logic [W-1:0] new_pc_o,
  output logic [W-1:0] msr_o,
  output logic         link_we_o,
  output logic [4:0]   link_idx_o,
  output logic [W-1:0] link_data_o,
  output logic         clr_flags_o,
  output logic [W-1:0] esr_o,
  output logic [W-1:0] btr_o,
  output logic [W-1:0] ear_o
);
  localparam logic [W-1:0] PC_IRQ = W'(VEC_BASE + OFS_IRQ);
  localparam logic [W-1:0] PC_BRK = W'(VEC_BASE + OFS_BRK);
  localparam logic [W-1:0] PC_EXC = W'(VEC_BASE + OFS_EXC);

  ev_e          ev;
  logic [W-1:0] msr_d, link_d, esr_d, btr_d, ear_d, pc_d;
  logic         link_we_d;
  logic [4:0]   link_idx_d;
  logic         taken_d;

  exc_arbiter #(.W(W)) u_arb (
    .mmu_i      (mmu_fault_req_i),
    .hwexc_i    (hw_exc_req_i),
    .hwbrk_i    (hw_break_req_i),
    .swbrk_i    (sw_break_req_i),
    .irq_i      (irq_i),
    .exc_en_i   (cfg_exc_en_i),
    .msr_i      (msr_i),
    .in_dslot_i (in_dslot_i),
    .has_imm_i  (has_imm_i),
    .ev_o       (ev)
  );

  exc_msr_update #(.W(W)) u_msr (
    .ev_i  (ev),
    .msr_i (msr_i),
    .msr_o (msr_d)
  );

  exc_link_calc #(.W(W)) u_link (
    .ev_i         (ev),
    .pc_i         (pc_i),
    .in_dslot_i   (in_dslot_i),
    .has_imm_i    (has_imm_i),
    .branch_imm_i (branch_imm_i),
    .we_o         (link_we_d),
    .idx_o        (link_idx_d),
    .data_o       (link_d)
  );

  exc_syndrome #(.W(W)) u_syn (
    .ev_i         (ev),
    .in_dslot_i   (in_dslot_i),
    .kind_i       (mmu_kind_i),
    .acc_i        (mmu_acc_i),
    .btarget_i    (btarget_i),
    .fault_addr_i (fault_addr_i),
    .esr_q_i      (esr_o),
    .btr_q_i      (btr_o),
    .ear_q_i      (ear_o),
    .esr_d_o      (esr_d),
    .btr_d_o      (btr_d),
    .ear_d_o      (ear_d)
  );

  always_comb begin
    taken_d = (ev != EV_NONE);
    unique case (ev)
      EV_IRQ:          pc_d = PC_IRQ;
      EV_HWBRK:        pc_d = PC_BRK;
      EV_SWBRK:        pc_d = btarget_i;
      EV_MMU, EV_HWEXC: pc_d = PC_EXC;
      default:         pc_d = new_pc_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_taken_o <= 1'b0;
      new_pc_o      <= '0;
      msr_o         <= '0;
      link_we_o     <= 1'b0;
      link_idx_o    <= '0;
      link_data_o   <= '0;
      clr_flags_o   <= 1'b0;
      esr_o         <= '0;
      btr_o         <= '0;
      ear_o         <= '0;
    end else begin
      entry_taken_o <= taken_d;
      new_pc_o      <= pc_d;
      link_we_o     <= link_we_d;
      clr_flags_o   <= (ev == EV_MMU) || (ev == EV_HWEXC);
      esr_o         <= esr_d;
      btr_o         <= btr_d;
      ear_o         <= ear_d;
      if (taken_d) msr_o <= msr_d;
      if (link_we_d) begin
        link_idx_o  <= link_idx_d;
        link_data_o <= link_d;
      end
    end
  end

  assert_irq_vec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_taken_o && link_we_o && link_idx_o == LINK_IRQ |-> new_pc_o == PC_IRQ);

  assert_irq_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_taken_o && link_we_o && link_idx_o == LINK_IRQ |->
      $past(msr_i[MSR_IE]) && !$past(msr_i[MSR_EIP]) && !$past(msr_i[MSR_BIP])
      && !$past(in_dslot_i) && !$past(has_imm_i));

  assert_mode_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_taken_o |-> !msr_o[MSR_UM] && !msr_o[MSR_VM]);

  assert_exc_eip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_taken_o && link_we_o && link_idx_o == LINK_EXC |-> msr_o[MSR_EIP]);

  assert_ear_only_on_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ear_o) |-> entry_taken_o && clr_flags_o);

  assert_swbrk_bip_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_taken_o && !link_we_o |-> msr_o[MSR_BIP] && new_pc_o == $past(btarget_i));

  assert_clr_only_exc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flags_o |-> entry_taken_o && link_we_o && link_idx_o == LINK_EXC);
endmodule

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int NV = 20;

  // req = {mmu, hwexc, hwbrk, swbrk, irq}; fl = {dslot, imm, bimm}
  typedef struct packed {
    logic [4:0]  req;
    logic        en;
    logic [31:0] msr;
    logic [31:0] pc;
    logic [31:0] bt;
    logic [31:0] fa;
    logic [2:0]  fl;
    logic        kind;
    logic [1:0]  acc;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{5'b00001, 1'b1, 32'h2802, 32'h100, 32'h0, 32'h0, 3'b000, 1'b0, 2'd0}, // irq taken
    '{5'b00001, 1'b1, 32'h0800, 32'h104, 32'h0, 32'h0, 3'b000, 1'b0, 2'd0}, // IE off
    '{5'b00001, 1'b1, 32'h0a02, 32'h108, 32'h0, 32'h0, 3'b000, 1'b0, 2'd0}, // EIP set
    '{5'b00001, 1'b1, 32'h000a, 32'h10c, 32'h0, 32'h0, 3'b000, 1'b0, 2'd0}, // BIP set
    '{5'b00001, 1'b1, 32'h0002, 32'h110, 32'h0, 32'h0, 3'b100, 1'b0, 2'd0}, // dslot
    '{5'b00001, 1'b1, 32'h0002, 32'h114, 32'h0, 32'h0, 3'b010, 1'b0, 2'd0}, // imm
    '{5'b01000, 1'b1, 32'h0802, 32'h200, 32'h0, 32'h0, 3'b000, 1'b0, 2'd0}, // hwexc
    '{5'b01000, 1'b0, 32'h0802, 32'h204, 32'hbad0, 32'h0, 3'b100, 1'b0, 2'd0}, // hwexc off
    '{5'b01000, 1'b1, 32'h0000, 32'h208, 32'habc0, 32'h0, 3'b100, 1'b0, 2'd0}, // hwexc dslot
    '{5'b10000, 1'b1, 32'h2800, 32'h300, 32'h0, 32'hdead0000, 3'b000, 1'b0, 2'd0}, // prot fetch
    '{5'b10000, 1'b1, 32'h0000, 32'h400, 32'h5550, 32'hbeef0004, 3'b100, 1'b0, 2'd2}, // prot store ds
    '{5'b10000, 1'b1, 32'h0000, 32'h500, 32'h6660, 32'h12340008, 3'b101, 1'b1, 2'd1}, // miss load ds+bimm
    '{5'b10000, 1'b1, 32'h0000, 32'h600, 32'h0, 32'h0000000c, 3'b010, 1'b1, 2'd0}, // miss fetch imm
    '{5'b00100, 1'b1, 32'h2000, 32'h700, 32'h0, 32'h0, 3'b000, 1'b0, 2'd0}, // hwbrk
    '{5'b00010, 1'b1, 32'h0800, 32'h704, 32'h7770, 32'h0, 3'b000, 1'b0, 2'd0}, // swbrk
    '{5'b11111, 1'b1, 32'h0002, 32'h800, 32'h8880, 32'h00000010, 3'b000, 1'b0, 2'd2}, // all: mmu
    '{5'b01111, 1'b1, 32'h0002, 32'h900, 32'h9990, 32'h0, 3'b000, 1'b0, 2'd0}, // hwexc wins
    '{5'b00111, 1'b1, 32'h0002, 32'ha00, 32'haaa0, 32'h0, 3'b000, 1'b0, 2'd0}, // hwbrk wins
    '{5'b00011, 1'b1, 32'h0002, 32'hb00, 32'hbbb0, 32'h0, 3'b000, 1'b0, 2'd0}, // swbrk wins
    '{5'b01001, 1'b0, 32'h0002, 32'hc00, 32'h0, 32'h0, 3'b000, 1'b0, 2'd0}  // hwexc off, irq
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] pc, msr, bt, fa;
  logic dslot, imm, bimm, en, irq, hwexc, mmu, kind, swbrk, hwbrk;
  logic [1:0] acc;

  logic        taken, lwe, clr;
  logic [31:0] npc, nmsr, ldata, esr, btr, ear;
  logic [4:0]  lidx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_esr, m_btr, m_ear;
  logic        e_taken, e_we, e_clr;
  logic [31:0] e_pc, e_msr, e_data;
  logic [4:0]  e_idx;
  string       e_tag;

  always #2.5 clk = ~clk;

  exc_entry_ctrl #(.VEC_BASE(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .msr_i(msr), .btarget_i(bt),
    .fault_addr_i(fa), .in_dslot_i(dslot), .has_imm_i(imm), .branch_imm_i(bimm),
    .cfg_exc_en_i(en), .irq_i(irq), .hw_exc_req_i(hwexc), .mmu_fault_req_i(mmu),
    .mmu_kind_i(kind), .mmu_acc_i(acc), .sw_break_req_i(swbrk), .hw_break_req_i(hwbrk),
    .entry_taken_o(taken), .new_pc_o(npc), .msr_o(nmsr), .link_we_o(lwe),
    .link_idx_o(lidx), .link_data_o(ldata), .clr_flags_o(clr),
    .esr_o(esr), .btr_o(btr), .ear_o(ear)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    {mmu, hwexc, hwbrk, swbrk, irq} = v.req;
    en = v.en; msr = v.msr; pc = v.pc; bt = v.bt; fa = v.fa;
    {dslot, imm, bimm} = v.fl; kind = v.kind; acc = v.acc;
  endtask

  task automatic idle();
    {mmu, hwexc, hwbrk, swbrk, irq} = '0;
    dslot = 1'b0; imm = 1'b0; bimm = 1'b0;
  endtask

  task automatic model(input vec_t v);
    logic ds, im, bi, irq_ok;
    int   ev; // 0 none 1 mmu 2 hwexc 3 hwbrk 4 swbrk 5 irq
    {ds, im, bi} = v.fl;
    irq_ok = v.msr[1] && !v.msr[9] && !v.msr[3] && !ds && !im;
    if (v.req[4])              ev = 1;
    else if (v.req[3] && v.en) ev = 2;
    else if (v.req[2])         ev = 3;
    else if (v.req[1])         ev = 4;
    else if (v.req[0] && irq_ok) ev = 5;
    else                       ev = 0;
    e_taken = (ev != 0);
    e_we = 1'b0; e_clr = 1'b0; e_idx = 5'd0; e_data = 32'h0; e_pc = 32'h0;
    e_msr = v.msr;
    e_msr[12] = v.msr[11]; e_msr[14] = v.msr[13];
    e_msr[11] = 1'b0; e_msr[13] = 1'b0;
    case (ev)
      1: begin
        e_tag = "R7/R9 mmu";
        e_pc = BASE + 32'h20; e_msr[9] = 1'b1; e_clr = 1'b1;
        e_we = 1'b1; e_idx = 5'd17;
        e_data = ds ? (bi ? v.pc - 8 : v.pc - 4) : (im ? v.pc - 4 : v.pc);
        m_esr = 32'd16 + (v.kind ? 32'd2 : 32'd0) + ((v.acc == 2'd0) ? 32'd1 : 32'd0);
        if (v.acc == 2'd2) m_esr = m_esr | 32'h400;
        if (ds) m_esr = m_esr | 32'h1000;
        if (ds) m_btr = v.bt;
        m_ear = v.fa;
      end
      2: begin
        e_tag = "R6/R8 hwexc";
        e_pc = BASE + 32'h20; e_msr[9] = 1'b1; e_clr = 1'b1;
        e_we = 1'b1; e_idx = 5'd17; e_data = v.pc + 4;
        m_esr = ds ? (m_esr | 32'h1000) : (m_esr & ~32'h1000);
        if (ds) m_btr = v.bt;
      end
      3: begin
        e_tag = "R10 hwbrk";
        e_pc = BASE + 32'h18; e_msr[3] = 1'b1;
        e_we = 1'b1; e_idx = 5'd16; e_data = v.pc;
      end
      4: begin
        e_tag = "R10 swbrk";
        e_pc = v.bt; e_msr[3] = 1'b1;
      end
      5: begin
        e_tag = "R5 irq";
        e_pc = BASE + 32'h10; e_msr[1] = 1'b0;
        e_we = 1'b1; e_idx = 5'd14; e_data = v.pc;
      end
      default: e_tag = "R3/R6 no entry";
    endcase
  endtask

  task automatic check_entry();
    chk({e_tag, " R1 taken"}, {31'b0, taken}, {31'b0, e_taken});
    chk({e_tag, " R11 clr"}, {31'b0, clr}, {31'b0, e_clr});
    chk({e_tag, " link_we"}, {31'b0, lwe}, {31'b0, e_we});
    if (e_taken) begin
      chk({e_tag, " R2 pc"}, npc, e_pc);
      chk({e_tag, " R4 msr"}, nmsr, e_msr);
    end
    if (e_we) begin
      chk({e_tag, " link idx"}, {27'b0, lidx}, {27'b0, e_idx});
      chk({e_tag, " link data"}, ldata, e_data);
    end
    chk({e_tag, " R8/R9 esr"}, esr, m_esr);
    chk({e_tag, " R8 btr"}, btr, m_btr);
    chk({e_tag, " R9 ear"}, ear, m_ear);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); en = 1'b1; msr = '0; pc = '0; bt = '0; fa = '0; kind = 1'b0; acc = 2'd0;
    m_esr = '0; m_btr = '0; m_ear = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 taken", {31'b0, taken}, 32'h0);
    chk("R12 link_we", {31'b0, lwe}, 32'h0);
    chk("R12 clr", {31'b0, clr}, 32'h0);
    chk("R12 esr", esr, 32'h0);
    chk("R12 btr", btr, 32'h0);
    chk("R12 ear", ear, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle after release", {31'b0, taken}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      model(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      check_entry();
      idle();
      @(posedge clk);
      @(negedge clk);
      chk("R1 strobe drops", {31'b0, taken}, 32'h0);
      chk("R1 link_we drops", {31'b0, lwe}, 32'h0);
      chk("R9 ear holds", ear, m_ear);
    end

    // R1 back-to-back grants give a strobe on each cycle
    drive(VECS[13]);
    @(posedge clk);
    #1 drive(VECS[0]);
    @(negedge clk);
    chk("R1 first of pair", {31'b0, taken}, 32'h1);
    chk("R1 first pc", npc, BASE + 32'h18);
    @(posedge clk);
    @(negedge clk);
    chk("R1 second of pair", {31'b0, taken}, 32'h1);
    chk("R1 second pc", npc, BASE + 32'h10);
    idle();
    @(posedge clk);
    @(negedge clk);
    chk("R1 pair end", {31'b0, taken}, 32'h0);

    // R12 asynchronous reset clears owned registers
    #1 rst_n = 1'b0;
    #1;
    chk("R12 async esr", esr, 32'h0);
    chk("R12 async ear", ear, 32'h0);
    chk("R12 async btr", btr, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule